// File: doc/BRIEF.md
# Timer Gate Conditioner

This block decides, cycle by cycle, whether a 16-bit up-counter may advance. An external gate signal is brought into the clock domain through a two-flop synchronizer. It can then be inverted and passed through a toggle flip-flop, or it can be captured as a single pulse. The conditioned gate is combined with a timer tick-enable input to form the count-enable that drives the counter. The counter is part of the block so that the whole path can be observed.

Software controls the block through one 8-bit control register that is written and read back over a simple port. When gating is switched off, the counter advances on every tick. When gating is switched on, it advances only on ticks that arrive while the conditioned gate is open. Single-pulse mode measures one gate pulse: software arms it, the gate opens on the next active edge and closes on the inactive edge after that, and the hardware then clears the arm flag to report completion.

Top module: `tmr_gate_ctl`

## Requirements
- R1: While reset is high, and at the first sample after it, `cnt_val` is 0, `cnt_en` is 0 and `cfg_rdata` is 0x00.
- R2: Control register layout. Bit 7 is gating on, bit 6 is active-high level, bit 5 is toggle mode, bit 4 is single-pulse mode and bit 3 is arm/done; all five are writable. Bit 2 is the read-only gate state, and writes to it are ignored. Bits 1 and 0 always read 0. A write appears on `cfg_rdata` two cycles after the write strobe.
- R3: With toggle mode and single-pulse mode both off, the conditioned gate is open when the synchronized gate equals bit 6. If bit 6 is 1 the gate is open while the pin is high; if bit 6 is 0 it is open while the pin is low.
- R4: If bit 7 is 0, `cnt_en` equals `tick_en` delayed by one cycle. If bit 7 is 1, `cnt_en` is `tick_en` ANDed with the conditioned gate.
- R5: Bit 2 on read-back shows the conditioned gate whatever the value of bit 7.
- R6: With toggle mode on and single-pulse mode off, the conditioned gate is a flip-flop. It inverts on each rising edge of the gate after polarity adjustment, so after N active pulses it reads N mod 2.
- R7: While toggle mode is 0, the toggle flip-flop is held at 0. When toggle mode is turned on again, the gate therefore starts closed.
- R8: In single-pulse mode, a write with bits 4 and 3 both 1 arms the block. The gate opens on the first active edge after arming and closes on the next inactive edge. At that moment bit 3 clears by itself. An active pin of W cycles yields exactly W counts.
- R9: In single-pulse mode the gate stays closed while bit 3 is 0. This covers the time before arming and after completion. A pin that is already active when the block is armed does not open the gate until it has gone inactive and active again.
- R10: Bit 3 reads 0 whenever bit 4 is 0. A write that clears bit 4 also clears bit 3, and bit 3 cannot be set while bit 4 is 0.
- R11: `cnt_val` increases by 1 after each cycle in which `cnt_en` is 1 and holds otherwise. The path from pin to count has equal latency on opening and closing, so a gate open for W cycles with a steady tick gives W counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Registered control register read-back |
| gate_in | input | 1 | Asynchronous external gate pin |
| tick_en | input | 1 | Timer clock-enable |
| cnt_en | output | 1 | Registered count-enable |
| cnt_val | output | CNT_W | Up-counter value |

## Verification
The hardest state to reach from the ports is a single-pulse capture that starts while the pin is already active. The block must ignore that level and wait for a full inactive-to-active cycle. The bench holds the pin active, arms the block, and checks that no counts accumulate. It then drops the pin and raises it for a known width, and checks that the count equals that width. A second hard case is a toggle flip-flop left at 1 when toggle mode is switched off. The bench drives an odd number of pulses, clears toggle mode and then sets it again, and reads the gate-state bit to see that the flip-flop was cleared.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
  localparam int CTRL_W    = 8;
  localparam int F_GATE_ON = 7;
  localparam int F_LVL_HI  = 6;
  localparam int F_FLIP    = 5;
  localparam int F_ONESHOT = 4;
  localparam int F_ARM     = 3;
  localparam int F_STATE   = 2;
endpackage

// File: rtl/tgc_sync.sv
module tgc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic lvl_d
);
  logic [STAGES-1:0] stg;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg  <= '0;
      last <= 1'b0;
    end else begin
      stg  <= {stg[STAGES-2:0], din};
      last <= stg[STAGES-1];
    end
  end

  assign lvl   = stg[STAGES-1];
  assign lvl_d = last;
endmodule

// File: rtl/tgc_cond.sv
module tgc_cond (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic lvl_d,
  input  logic level_hi,
  input  logic flip_mode,
  input  logic one_shot,
  input  logic arm_wr_en,
  input  logic arm_wr_val,
  output logic arm_q,
  output logic gate_q
);
  logic pa, pa_prev, rise, fall;
  logic tff, sp_open, gate_d;

  // polarity-adjusted gate and its edges
  assign pa      = level_hi ? lvl   : ~lvl;
  assign pa_prev = level_hi ? lvl_d : ~lvl_d;
  assign rise    = pa & ~pa_prev;
  assign fall    = ~pa & pa_prev;

  always_ff @(posedge clk) begin
    if (rst || !flip_mode) tff <= 1'b0;
    else if (rise)         tff <= ~tff;
  end

  always_ff @(posedge clk) begin
    if (rst)                    arm_q <= 1'b0;
    else if (arm_wr_en)         arm_q <= arm_wr_val;
    else if (!one_shot)         arm_q <= 1'b0;
    else if (sp_open && fall)   arm_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || !one_shot || !arm_q) sp_open <= 1'b0;
    else if (!sp_open && rise)      sp_open <= 1'b1;
    else if (sp_open && fall)       sp_open <= 1'b0;
  end

  always_comb begin
    if (one_shot)       gate_d = sp_open;
    else if (flip_mode) gate_d = tff;
    else                gate_d = pa;
  end

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= gate_d;
  end

  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (flip_mode && rise) |=> (tff != $past(tff)));
  // R7
  toggle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !flip_mode |=> !tff);
  // R8
  pulse_close_chk: assert property (@(posedge clk) disable iff (rst)
    (one_shot && sp_open && fall && !arm_wr_en) |=> (!arm_q && !sp_open));
  // R9
  pulse_open_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sp_open) |-> $past(arm_q));
  // R10
  arm_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!one_shot && !arm_wr_en) |=> !arm_q);
endmodule

// File: rtl/tgc_counter.sv
module tgc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] val
);
  always_ff @(posedge clk) begin
    if (rst)      val <= '0;
    else if (inc) val <= val + 1'b1;
  end

  // R11
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    inc |=> (val == $past(val) + 1'b1));
endmodule

// File: rtl/tmr_gate_ctl.sv
module tmr_gate_ctl
  import tgc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] cfg_rdata,
  input  logic              gate_in,
  input  logic              tick_en,
  output logic              cnt_en,
  output logic [CNT_W-1:0]  cnt_val
);
  logic gate_on_q, level_hi_q, flip_q, one_q;
  logic lvl, lvl_d, arm_q, gate_q;
  logic wdata_unused;

  assign wdata_unused = ^cfg_wdata[F_STATE:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_on_q  <= 1'b0;
      level_hi_q <= 1'b0;
      flip_q     <= 1'b0;
      one_q      <= 1'b0;
    end else if (cfg_we) begin
      gate_on_q  <= cfg_wdata[F_GATE_ON];
      level_hi_q <= cfg_wdata[F_LVL_HI];
      flip_q     <= cfg_wdata[F_FLIP];
      one_q      <= cfg_wdata[F_ONESHOT];
    end
  end

  tgc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(gate_in), .lvl(lvl), .lvl_d(lvl_d)
  );

  tgc_cond u_cond (
    .clk(clk), .rst(rst), .lvl(lvl), .lvl_d(lvl_d),
    .level_hi(level_hi_q), .flip_mode(flip_q), .one_shot(one_q),
    .arm_wr_en(cfg_we),
    .arm_wr_val(cfg_wdata[F_ARM] & cfg_wdata[F_ONESHOT]),
    .arm_q(arm_q), .gate_q(gate_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_en    <= 1'b0;
      cfg_rdata <= '0;
    end else begin
      cnt_en    <= tick_en & (~gate_on_q | gate_q);
      cfg_rdata <= {gate_on_q, level_hi_q, flip_q, one_q, arm_q, gate_q, 2'b00};
    end
  end

  tgc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(cnt_en), .val(cnt_val)
  );

  // R4
  ungated_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !gate_on_q |=> (cnt_en == $past(tick_en)));
  // R4
  gated_block_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_on_q && !gate_q) |=> !cnt_en);
  // R2
  spare_bits_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[1:0] == 2'b00);
endmodule

// File: tb/tb_tmr_gate_ctl.sv
`timescale 1ns/1ps
module tb_tmr_gate_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        gate_in = 1'b0;
  logic        tick_en = 1'b0;
  logic        cnt_en;
  logic [15:0] cnt_val;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tmr_gate_ctl dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .gate_in(gate_in), .tick_en(tick_en),
    .cnt_en(cnt_en), .cnt_val(cnt_val)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    cyc(2);
    d = cfg_rdata;
  endtask

  task automatic pulse(input logic act_lvl, input int w);
    gate_in = act_lvl; cyc(w);
    gate_in = ~act_lvl; cyc(8);
  endtask

  initial begin
    logic [7:0] r;
    logic [15:0] c0;
    cyc(3);
    // R1 reset state
    chk("R1 cnt_val", int'(cnt_val), 0);
    chk("R1 cnt_en", int'(cnt_en), 0);
    chk("R1 rdata", int'(cfg_rdata), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rdata after release", int'(cfg_rdata), 0);

    // R2 layout
    wr(8'hC7); rd(r);
    chk("R2 rw bits", int'(r & 8'hFB), 'hC0);
    wr(8'h28); rd(r);
    chk("R2 flip bit, arm blocked R10", int'(r & 8'hFB), 'h20);
    wr(8'h00); rd(r);
    chk("R2 clear", int'(r & 8'hFB), 0);

    // R3/R4/R5/R11 exhaustive static sweep
    for (int k = 0; k < 16; k++) begin
      logic on, hi, g, t, open_g, exp_en;
      on = k[3]; hi = k[2]; g = k[1]; t = k[0];
      wr({on, hi, 6'b0});
      gate_in = g; tick_en = t;
      cyc(8);
      open_g = (g == hi);
      exp_en = t & (~on | open_g);
      chk("R4 cnt_en", int'(cnt_en), int'(exp_en));
      chk("R3 R5 gate state", int'(cfg_rdata[2]), int'(open_g));
      c0 = cnt_val; cyc(10);
      chk("R11 count delta", int'(cnt_val - c0), 10 * int'(exp_en));
    end

    // R6 toggle, both polarities
    tick_en = 1'b1;
    for (int p = 0; p < 2; p++) begin
      logic hi;
      hi = p[0];
      gate_in = ~hi; wr({1'b1, hi, 6'b0}); cyc(6);
      wr({1'b1, hi, 1'b1, 5'b0}); cyc(4);
      rd(r);
      chk("R6 toggle start", int'(r[2]), 0);
      for (int n = 1; n <= 5; n++) begin
        pulse(hi, 4);
        rd(r);
        chk("R6 toggle count", int'(r[2]), n % 2);
      end
      // R7 flip-flop left at 1, clear mode then re-enable
      wr({1'b1, hi, 6'b0}); cyc(4);
      wr({1'b1, hi, 1'b1, 5'b0}); cyc(4);
      rd(r);
      chk("R7 toggle cleared", int'(r[2]), 0);
    end

    // R9 one-shot without arm
    gate_in = 1'b0; wr(8'hD0); cyc(6);
    c0 = cnt_val; pulse(1'b1, 6);
    chk("R9 unarmed no count", int'(cnt_val - c0), 0);

    // R8 armed capture
    wr(8'hD8); rd(r);
    chk("R8 armed flag", int'(r[3]), 1);
    chk("R8 gate closed while armed", int'(r[2]), 0);
    c0 = cnt_val; pulse(1'b1, 7); cyc(4);
    chk("R8 pulse width counted", int'(cnt_val - c0), 7);
    rd(r);
    chk("R8 done clears arm", int'(r[3]), 0);
    c0 = cnt_val; pulse(1'b1, 5);
    chk("R9 after done no count", int'(cnt_val - c0), 0);

    // R9 armed while already active
    gate_in = 1'b1; cyc(6);
    wr(8'hD8); c0 = cnt_val; cyc(12);
    chk("R9 active at arm no count", int'(cnt_val - c0), 0);
    gate_in = 1'b0; cyc(6);
    c0 = cnt_val; pulse(1'b1, 3); cyc(4);
    chk("R9 next full pulse counted", int'(cnt_val - c0), 3);

    // R10 clearing single-pulse clears arm
    wr(8'hD8); rd(r);
    chk("R10 armed", int'(r[3]), 1);
    wr(8'hC8); rd(r);
    chk("R10 arm cleared with mode", int'(r[3]), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule